// File: doc/BRIEF.md
# Receive/Transmit Hardware Handshake Controller

This block runs the request-to-send / clear-to-send handshake for one serial channel. On the receive side it watches how many characters sit in the receive FIFO and drives an active-low request-to-send output. When automatic mode is on, that output is released once the FIFO has filled one step past the selected trigger level. It is driven active again only after the FIFO has drained to one step below that level. The gap between these two points gives the remote sender hysteresis. The receive FIFO keeps accepting data until it is full, and a separate flag still marks the selected trigger level itself.

On the transmit side, an active-low clear-to-send input passes through a two-flop synchronizer. When automatic mode is on and the remote end withdraws clear-to-send, the block lowers a transmit-allow output. If the local transmitter is idle, this happens at once. If a character is in flight, it happens only when the transmitter reports that the stop bit has gone out. A shared flow-control interrupt flag is raised by a low-to-high edge of request-to-send or by clear-to-send being withdrawn, each under its own enable. The flag stays set until it is acknowledged.

Top module: `rts_cts_flow`

## Requirements
- R1: After reset, rts_n is 1, tx_allow is 1, fc_irq is 0 and rx_at_trig is 0.
- R2: With auto_rts_en low, rts_n equals the inverse of rts_sw, one clock after the sample.
- R3: trig_sel encodes the trigger level as 0→8, 1→16, 2→24, 3→28 characters. rx_at_trig is 1, one clock later, exactly when rx_count is at least that level.
- R4: With auto_rts_en and rts_sw both high, rts_n goes to 1 one clock after rx_count reaches the release point for the selected level: 16, 24, 28 or 28 for levels 8, 16, 24 or 28.
- R5: In the same mode, rts_n returns to 0 one clock after rx_count is at or below the reassert point: 0, 8, 16 or 24 for levels 8, 16, 24 or 28.
- R6: When rx_count lies strictly between the reassert point and the release point, rts_n keeps its previous value.
- R7: With rts_sw low, rts_n is 1 regardless of rx_count or auto_rts_en.
- R8: With rts_int_en and auto_rts_en high, the clock edge at which rts_n goes from 0 to 1 also sets fc_irq.
- R9: With auto_cts_en high and tx_busy low, tx_allow falls at the third clock edge after cts_n goes high.
- R10: While tx_busy is high, tx_allow stays high until a clock edge at which stop_done is high. At that edge it falls if the synchronized clear-to-send is withdrawn.
- R11: When cts_n returns low, tx_allow rises at the third clock edge after the change.
- R12: With auto_cts_en low, tx_allow is always 1. With auto_cts_en and cts_int_en both high, fc_irq is set at the second clock edge after cts_n goes high.
- R13: irq_ack clears fc_irq at the next edge unless a new set event occurs at that same edge, in which case the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 6 | Characters currently held in the receive FIFO |
| trig_sel | input | 2 | Receive trigger level select |
| auto_rts_en | input | 1 | Enable automatic request-to-send |
| auto_cts_en | input | 1 | Enable automatic clear-to-send gating |
| rts_int_en | input | 1 | Interrupt on request-to-send release |
| cts_int_en | input | 1 | Interrupt on clear-to-send withdrawal |
| rts_sw | input | 1 | Software request-to-send bit (1 = assert) |
| cts_n | input | 1 | Clear-to-send from the remote end, active low, asynchronous |
| tx_busy | input | 1 | Local transmitter is in the middle of a character |
| stop_done | input | 1 | One-cycle strobe: stop bit fully sent |
| irq_ack | input | 1 | Clears the flow-control interrupt flag |
| rts_n | output | 1 | Request-to-send, active low |
| tx_allow | output | 1 | Transmitter may start a new character |
| rx_at_trig | output | 1 | Receive FIFO at or above the trigger level |
| fc_irq | output | 1 | Flow-control interrupt flag |

## Verification
Every receive-side result (rts_n, rx_at_trig and the request-to-send interrupt) is registered once, so the bench drives on the falling edge and reads one rising edge later, at the next falling edge. Clear-to-send results pass through the synchronizer first. The interrupt is due after two edges and tx_allow after three, so the bench checks both the value just before the due edge and the value just after it. The hysteresis sweep ramps rx_count up and down across the whole range for each level, with an arithmetic model of the expected state.

// File: rtl/rts_cts_flow.sv
module rts_cts_flow #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_count,
  input  logic [1:0]    trig_sel,
  input  logic          auto_rts_en,
  input  logic          auto_cts_en,
  input  logic          rts_int_en,
  input  logic          cts_int_en,
  input  logic          rts_sw,
  input  logic          cts_n,
  input  logic          tx_busy,
  input  logic          stop_done,
  input  logic          irq_ack,
  output logic          rts_n,
  output logic          tx_allow,
  output logic          rx_at_trig,
  output logic          fc_irq
);
  localparam logic [CW-1:0] LV0 = CW'(8);
  localparam logic [CW-1:0] LV1 = CW'(16);
  localparam logic [CW-1:0] LV2 = CW'(24);
  localparam logic [CW-1:0] LV3 = CW'(28);

  logic [CW-1:0] lvl, hi, lo;
  logic off_q, off_d, rts_n_d;
  logic cts_s1, cts_s2, allow_d;
  logic rts_rise, cts_rise;

  always_comb begin
    case (trig_sel)
      2'd0:    begin lvl = LV0; hi = LV1; lo = '0;  end
      2'd1:    begin lvl = LV1; hi = LV2; lo = LV0; end
      2'd2:    begin lvl = LV2; hi = LV3; lo = LV1; end
      default: begin lvl = LV3; hi = LV3; lo = LV2; end
    endcase
  end

  always_comb begin
    if (!auto_rts_en || !rts_sw) off_d = 1'b0;
    else if (rx_count >= hi)     off_d = 1'b1;
    else if (rx_count <= lo)     off_d = 1'b0;
    else                         off_d = off_q;
  end

  assign rts_n_d  = !rts_sw || off_d;
  assign rts_rise = rts_int_en && auto_rts_en && rts_n_d && !rts_n;
  assign cts_rise = cts_int_en && auto_cts_en && cts_s1 && !cts_s2;

  always_comb begin
    if (!auto_cts_en || !cts_s2)   allow_d = 1'b1;
    else if (!tx_busy || stop_done) allow_d = 1'b0;
    else                            allow_d = tx_allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q      <= 1'b0;
      rts_n      <= 1'b1;
      cts_s1     <= 1'b0;
      cts_s2     <= 1'b0;
      tx_allow   <= 1'b1;
      rx_at_trig <= 1'b0;
      fc_irq     <= 1'b0;
    end else begin
      off_q      <= off_d;
      rts_n      <= rts_n_d;
      cts_s1     <= cts_n;
      cts_s2     <= cts_s1;
      tx_allow   <= allow_d;
      rx_at_trig <= (rx_count >= lvl);
      fc_irq     <= rts_rise || cts_rise || (fc_irq && !irq_ack);
    end
  end
endmodule

// File: rtl/rts_cts_flow_chk.sv
module rts_cts_flow_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_count,
  input logic          auto_rts_en,
  input logic          auto_cts_en,
  input logic          rts_int_en,
  input logic          cts_int_en,
  input logic          rts_sw,
  input logic          tx_busy,
  input logic          stop_done,
  input logic          irq_ack,
  input logic          rts_n,
  input logic          tx_allow,
  input logic          fc_irq
);
  p_sw_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n == !$past(rts_sw)));

  p_sw_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_sw |=> rts_n);

  p_full_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rts_sw && rx_count >= CW'(28)) |=> rts_n);

  p_empty_assert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rts_sw && rx_count == '0) |=> !rts_n);

  p_rts_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_int_en && $past(rts_int_en) && $past(auto_rts_en) && $rose(rts_n)) |-> fc_irq);

  p_cts_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |=> tx_allow);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_allow && tx_busy && !stop_done) |=> tx_allow);

  p_ack_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !rts_int_en && !cts_int_en) |=> !fc_irq);
endmodule

bind rts_cts_flow rts_cts_flow_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_count(rx_count),
  .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
  .rts_int_en(rts_int_en), .cts_int_en(cts_int_en), .rts_sw(rts_sw),
  .tx_busy(tx_busy), .stop_done(stop_done), .irq_ack(irq_ack),
  .rts_n(rts_n), .tx_allow(tx_allow), .fc_irq(fc_irq)
);

// File: tb/sim_rts_cts_flow.sv
`timescale 1ns/1ps
module sim_rts_cts_flow;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] rx_count = '0;
  logic [1:0] trig_sel = '0;
  logic auto_rts_en = 0, auto_cts_en = 0, rts_int_en = 0, cts_int_en = 0;
  logic rts_sw = 0, cts_n = 0, tx_busy = 0, stop_done = 0, irq_ack = 0;
  logic rts_n, tx_allow, rx_at_trig, fc_irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rts_cts_flow u0 (.*);

  task automatic chk(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R1 rts_n", rts_n, 1'b1);
    chk("R1 tx_allow", tx_allow, 1'b1);
    chk("R1 fc_irq", fc_irq, 1'b0);
    chk("R1 rx_at_trig", rx_at_trig, 1'b0);
    rst_n = 1'b1;
    step(3);

    // R2: software control only
    for (int i = 0; i < 4; i++) begin
      rts_sw = i[0];
      rx_count = 6'(i * 10);
      step();
      chk("R2 rts_n follows ~rts_sw", rts_n, !rts_sw);
    end

    // R7: sw low forces release even with auto on
    auto_rts_en = 1; rts_sw = 0;
    foreach (rx_count[k]) ;
    for (int c = 0; c <= 32; c += 8) begin
      rx_count = 6'(c);
      step();
      chk("R7 rts_n with sw low", rts_n, 1'b1);
    end

    // R3-R6, R8: hysteresis sweep per trigger level, ack held so fc_irq shows set edges
    rts_sw = 1; rts_int_en = 1; irq_ack = 1;
    for (int s = 0; s < 4; s++) begin
      int lvl, hi, lo;
      bit off;
      lvl = (s == 3) ? 28 : 8 * (s + 1);
      hi  = (s >= 2) ? 28 : 8 * (s + 2);
      lo  = 8 * s;
      trig_sel = 2'(s);
      rx_count = 0;
      step();
      off = 0;
      for (int p = 0; p < 66; p++) begin
        int c;
        bit prev;
        c = (p < 33) ? p : 65 - p;
        rx_count = 6'(c);
        prev = off;
        if (c >= hi) off = 1;
        else if (c <= lo) off = 0;
        step();
        if (c > lo && c < hi) chk("R6 hold between points", rts_n, off);
        else if (c >= hi)     chk("R4 release point", rts_n, off);
        else                  chk("R5 reassert point", rts_n, off);
        chk("R3 rx_at_trig", rx_at_trig, c >= lvl);
        chk("R8 irq on release", fc_irq, off && !prev);
      end
    end
    irq_ack = 0; rts_int_en = 0;

    // R8 negative: no irq when disabled
    rx_count = 0; step(); irq_ack = 1; step(); irq_ack = 0;
    rx_count = 32; step();
    chk("R4 release", rts_n, 1'b1);
    chk("R8 no irq when disabled", fc_irq, 1'b0);
    rx_count = 0; auto_rts_en = 0; step();

    // R12: auto cts off keeps allow
    cts_n = 1; step(5);
    chk("R12 allow with auto off", tx_allow, 1'b1);
    chk("R12 no irq with auto off", fc_irq, 1'b0);
    cts_n = 0; step(4);

    // R9 / R12 irq timing, idle transmitter
    auto_cts_en = 1; cts_int_en = 1;
    cts_n = 1;
    step(1); chk("R9 allow after 1 edge", tx_allow, 1'b1);
    chk("R12 irq not yet", fc_irq, 1'b0);
    step(1); chk("R9 allow after 2 edges", tx_allow, 1'b1);
    chk("R12 irq at 2nd edge", fc_irq, 1'b1);
    step(1); chk("R9 allow drops at 3rd edge", tx_allow, 1'b0);

    // R13: ack clears, set wins
    irq_ack = 1; step(); irq_ack = 0;
    chk("R13 ack clears", fc_irq, 1'b0);
    step(2); chk("R13 stays clear", fc_irq, 1'b0);

    // R11: resume
    cts_n = 0;
    step(2); chk("R11 still held after 2 edges", tx_allow, 1'b0);
    step(1); chk("R11 resume at 3rd edge", tx_allow, 1'b1);

    // R10: busy transmitter finishes its character
    tx_busy = 1; cts_n = 1;
    step(6); chk("R10 held high while busy", tx_allow, 1'b1);
    irq_ack = 1; stop_done = 1; step(); stop_done = 0; irq_ack = 0; tx_busy = 0;
    chk("R10 drops at stop_done", tx_allow, 1'b0);
    chk("R13 ack cleared cts flag", fc_irq, 1'b0);

    // R13 set wins over ack: new cts withdrawal coincides with ack
    cts_n = 0; step(4);
    cts_n = 1; step(1); irq_ack = 1; step(1); irq_ack = 0;
    chk("R13 set wins over ack", fc_irq, 1'b1);
    cts_n = 0; step(4);
    chk("R11 resumed", tx_allow, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule